// File: doc/BRIEF.md
# Control Register Read-Modify-Write Unit

This block carries out the three atomic control-register instructions: swap (read-write), bit-set (read-set) and bit-clear (read-clear). Each request supplies a 12-bit register address, a source operand, a flag that says whether the source register field of the instruction was non-zero, and the hart's current privilege level. The unit reads the addressed register, forms the new value and writes it back in the same clock edge. It returns the value from before the update on the destination path, one cycle after the request.

All three operations share one update formula: new = (old & ~mask) | (value & mask). The operation code only chooses the value and mask pair. A small register file holds four registers. Each one's privilege level comes from address bits [9:8], and address bits [11:10] equal to 2'b11 mark it read-only. An access that fails the legality check raises an illegal-instruction flag, leaves the register untouched and returns zero data.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_illegal and rsp_rdata are 0, the writable registers (addresses 0x041, 0x142, 0x343) hold 0, and the read-only register at 0xC44 holds RO_VALUE (default 32'h5A5A_0C3C).
- R2: Operation code 2'b01 (read-write) writes the source operand to the register and returns the previous value.
- R3: Operation code 2'b10 (read-set) sets every register bit that is 1 in the source operand and returns the previous value.
- R4: Operation code 2'b11 (read-clear) clears every register bit that is 1 in the source operand and returns the previous value.
- R5: For read-set and read-clear with req_src_nz = 0, the write mask is zero. The register keeps its value and the previous value is returned.
- R6: An access whose cur_priv (0 user, 1 supervisor, 3 machine) is below address bits [9:8] is illegal.
- R7: An access with a non-zero write mask to an address whose bits [11:10] are 2'b11 is illegal. A zero-mask access to such an address is a legal read.
- R8: An address that matches no register, or operation code 2'b00, is illegal.
- R9: rsp_valid, rsp_illegal and rsp_rdata update one clock after a request is sampled. rsp_valid is 0 in cycles after no request. An illegal response carries rsp_rdata = 0 and changes no register.
- R10: A request in the cycle right after another request to the same register sees the value written by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_op | input | 2 | 01 read-write, 10 read-set, 11 read-clear, 00 reserved |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register field was non-zero |
| cur_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response strobe |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_rdata | output | XLEN | Register value before the update |

## Verification
The write-back of one access and the read of the next can fall in the same cycle. When requests arrive back to back, the second one reads the register during the same clock in which the first one's result is stored. The bench provokes this by issuing a read-write and then a read-set to the same address on consecutive cycles. It judges the second response against the value written by the first, then checks the register again to confirm that both updates combined.

// File: rtl/csr_rmw_pkg.sv
// Shared types and register-map helpers for the read-modify-write unit.
// Assumes a 12-bit register address space.
package csr_rmw_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RW   = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    localparam int CSR_AW    = 12;
    localparam int CSR_COUNT = 4;

    // Address of register slot idx in the local file.
    function automatic logic [CSR_AW-1:0] csr_addr_of(input int idx);
        case (idx)
            0:       return 12'h041;
            1:       return 12'h142;
            2:       return 12'h343;
            default: return 12'hC44;
        endcase
    endfunction

    // Read-only attribute carried by address bits [11:10].
    function automatic logic csr_is_ro(input logic [CSR_AW-1:0] a);
        return a[11:10] == 2'b11;
    endfunction
endpackage

// File: rtl/csr_op_decode.sv
// Maps an operation code onto the value/mask pair of the shared masked write.
// Assumes src_nz reflects the instruction's source register field.
module csr_op_decode
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src,
    input  logic            src_nz,
    output logic [XLEN-1:0] value,
    output logic [XLEN-1:0] mask,
    output logic            op_ok
);
    localparam logic [XLEN-1:0] ONES = '1;

    // Select value and mask for the requested operation.
    always_comb begin
        value = '0;
        mask  = '0;
        op_ok = 1'b1;
        case (csr_op_e'(op))
            OP_RW: begin
                value = src;
                mask  = ONES;
            end
            OP_SET: begin
                value = ONES;
                mask  = src_nz ? src : '0;
            end
            OP_CLR: begin
                value = '0;
                mask  = src_nz ? src : '0;
            end
            default: op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/csr_access_check.sv
// Decides whether an access is legal: known op, known address, enough
// privilege, and no non-zero-mask write to a read-only register.
module csr_access_check
    import csr_rmw_pkg::*;
(
    input  logic              op_ok,
    input  logic              addr_hit,
    input  logic [CSR_AW-1:0] addr,
    input  logic [1:0]        priv,
    input  logic              mask_nz,
    output logic              illegal
);
    // Combine the four rejection causes.
    always_comb begin
        illegal = !op_ok || !addr_hit || (priv < addr[9:8])
                  || (mask_nz && csr_is_ro(addr));
    end
endmodule

// File: rtl/csr_regfile.sv
// Small register file of CSR_COUNT slots addressed by full 12-bit compare.
// Read-only slots hold RO_VALUE; writable slots reset to zero.
// Assumes write enable is only raised for legal, writable accesses.
module csr_regfile
    import csr_rmw_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RO_VALUE = 32'h5A5A_0C3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] addr,
    input  logic              we,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata,
    output logic              hit
);
    logic [CSR_COUNT-1:0]           hit_vec;
    logic [CSR_COUNT-1:0][XLEN-1:0] slot_q;

    for (genvar i = 0; i < CSR_COUNT; i++) begin : g_slot
        localparam logic [CSR_AW-1:0] SLOT_ADDR = csr_addr_of(i);
        assign hit_vec[i] = (addr == SLOT_ADDR);
        if (csr_is_ro(SLOT_ADDR)) begin : g_ro
            assign slot_q[i] = RO_VALUE;
        end else begin : g_rw
            logic [XLEN-1:0] q;
            // Hold or update one writable slot.
            always_ff @(posedge clk) begin
                if (!rst_n)                 q <= '0;
                else if (we && hit_vec[i])  q <= wdata;
            end
            assign slot_q[i] = q;
        end
    end

    // One-hot read mux built as an OR of selected slots.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < CSR_COUNT; i++)
            if (hit_vec[i]) rdata = rdata | slot_q[i];
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/csr_rmw_unit.sv
// Top of the read-modify-write unit: decode, legality, masked update and
// registered response one cycle after the request strobe.
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RO_VALUE = 32'h5A5A_0C3C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [11:0]     req_addr,
    input  logic [XLEN-1:0] req_src,
    input  logic            req_src_nz,
    input  logic [1:0]      cur_priv,
    output logic            rsp_valid,
    output logic            rsp_illegal,
    output logic [XLEN-1:0] rsp_rdata
);
    logic [XLEN-1:0] value, mask, old_val, new_val;
    logic            op_ok, hit, illegal, we;

    csr_op_decode #(.XLEN(XLEN)) u_dec (
        .op(req_op), .src(req_src), .src_nz(req_src_nz),
        .value(value), .mask(mask), .op_ok(op_ok)
    );

    csr_access_check u_chk (
        .op_ok(op_ok), .addr_hit(hit), .addr(req_addr), .priv(cur_priv),
        .mask_nz(|mask), .illegal(illegal)
    );

    // Shared masked update for all three operations.
    always_comb new_val = (old_val & ~mask) | (value & mask);

    assign we = req_valid && !illegal && (|mask);

    csr_regfile #(.XLEN(XLEN), .RO_VALUE(RO_VALUE)) u_rf (
        .clk(clk), .rst_n(rst_n), .addr(req_addr), .we(we),
        .wdata(new_val), .rdata(old_val), .hit(hit)
    );

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_illegal <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_illegal <= req_valid && illegal;
            rsp_rdata   <= (req_valid && !illegal) ? old_val : '0;
        end
    end
endmodule

// File: rtl/csr_rmw_unit_checker.sv
// Port-level properties of the read-modify-write unit, bound to the top.
module csr_rmw_unit_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [11:0]     req_addr,
    input logic [1:0]      cur_priv,
    input logic            rsp_valid,
    input logic            rsp_illegal,
    input logic [XLEN-1:0] rsp_rdata
);
    a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_illegal);
    a_r9_illegal_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> rsp_rdata == '0);
    a_r6_low_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_priv < req_addr[9:8]) |=> rsp_illegal);
    a_r7_ro_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:10] == 2'b11 && req_op == 2'b01) |=> rsp_illegal);
    a_r8_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |=> rsp_illegal);
endmodule

bind csr_rmw_unit csr_rmw_unit_checker #(.XLEN(XLEN)) u_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .cur_priv(cur_priv), .rsp_valid(rsp_valid),
    .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata)
);

// File: tb/csr_rmw_unit_bench.sv
// Directed bench for the read-modify-write unit.
module csr_rmw_unit_bench;
    localparam int XLEN = 32;
    localparam logic [31:0] RO_V = 32'h5A5A_0C3C;
    localparam logic [11:0] A_U = 12'h041, A_S = 12'h142, A_M = 12'h343,
                            A_RO = 12'hC44, A_BAD = 12'h045;
    localparam logic [1:0] RW = 2'b01, SET = 2'b10, CLR = 2'b11, NOP = 2'b00;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_op = '0;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_src = '0;
    logic            req_src_nz = 1'b0;
    logic [1:0]      cur_priv = '0;
    logic            rsp_valid, rsp_illegal;
    logic [XLEN-1:0] rsp_rdata;
    int n_vec = 0, n_bad = 0;

    always #2 clk = ~clk;

    csr_rmw_unit #(.XLEN(XLEN)) u_csr_rmw_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_src(req_src), .req_src_nz(req_src_nz),
        .cur_priv(cur_priv), .rsp_valid(rsp_valid),
        .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic v, input logic ill,
                         input logic [31:0] rd);
        n_vec++;
        if (rsp_valid !== v || rsp_illegal !== ill || rsp_rdata !== rd) begin
            n_bad++;
            $display("FAIL %s: got v=%b ill=%b rd=%h, expected v=%b ill=%b rd=%h",
                     tag, rsp_valid, rsp_illegal, rsp_rdata, v, ill, rd);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [11:0] a,
                         input logic [31:0] s, input logic nz, input logic [1:0] p);
        req_valid = 1'b1; req_op = op; req_addr = a;
        req_src = s; req_src_nz = nz; cur_priv = p;
    endtask

    // One isolated access with its response check.
    task automatic access(input string tag, input logic [1:0] op,
                          input logic [11:0] a, input logic [31:0] s,
                          input logic nz, input logic [1:0] p,
                          input logic ill, input logic [31:0] rd);
        @(negedge clk); drive(op, a, s, nz, p);
        @(posedge clk); #1 check(tag, 1'b1, ill, rd);
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic t_reset;   // R1
        @(negedge clk); #0 check("R1 reset outputs", 1'b0, 1'b0, '0);
        access("R1 user reg reset", SET, A_U, '0, 1'b0, 2'd3, 1'b0, '0);
        access("R1 super reg reset", SET, A_S, '0, 1'b0, 2'd3, 1'b0, '0);
        access("R1 machine reg reset", CLR, A_M, '0, 1'b0, 2'd3, 1'b0, '0);
        access("R1 read-only value", SET, A_RO, '0, 1'b0, 2'd0, 1'b0, RO_V);
    endtask

    task automatic t_swap;    // R2
        access("R2 swap returns old", RW, A_U, 32'hA5A5_0F0F, 1'b1, 2'd0, 1'b0, '0);
        access("R2 swap wrote src", RW, A_U, 32'h1, 1'b1, 2'd0, 1'b0, 32'hA5A5_0F0F);
    endtask

    task automatic t_set;     // R3
        access("R3 set first", SET, A_M, 32'hF0, 1'b1, 2'd3, 1'b0, '0);
        access("R3 set second", SET, A_M, 32'h0F, 1'b1, 2'd3, 1'b0, 32'hF0);
        access("R3 set result", SET, A_M, '0, 1'b0, 2'd3, 1'b0, 32'hFF);
    endtask

    task automatic t_clear;   // R4
        access("R4 clear returns old", CLR, A_M, 32'h30, 1'b1, 2'd3, 1'b0, 32'hFF);
        access("R4 clear result", SET, A_M, '0, 1'b0, 2'd3, 1'b0, 32'hCF);
    endtask

    task automatic t_zero_src; // R5
        access("R5 clear no-src", CLR, A_M, '1, 1'b0, 2'd3, 1'b0, 32'hCF);
        access("R5 set no-src", SET, A_M, '1, 1'b0, 2'd3, 1'b0, 32'hCF);
        access("R5 value kept", RW, A_M, 32'hCF, 1'b1, 2'd3, 1'b0, 32'hCF);
    endtask

    task automatic t_priv;    // R6
        access("R6 machine from super", RW, A_M, '0, 1'b1, 2'd1, 1'b1, '0);
        access("R6 machine untouched", SET, A_M, '0, 1'b0, 2'd3, 1'b0, 32'hCF);
        access("R6 super from user", RW, A_S, 32'h77, 1'b1, 2'd0, 1'b1, '0);
        access("R6 super from super", RW, A_S, 32'h77, 1'b1, 2'd1, 1'b0, '0);
        access("R6 super written", SET, A_S, '0, 1'b0, 2'd1, 1'b0, 32'h77);
    endtask

    task automatic t_ro;      // R7
        access("R7 swap read-only", RW, A_RO, '0, 1'b1, 2'd3, 1'b1, '0);
        access("R7 zero mask legal", SET, A_RO, '0, 1'b1, 2'd3, 1'b0, RO_V);
        access("R7 set read-only", SET, A_RO, 32'h1, 1'b1, 2'd3, 1'b1, '0);
        access("R7 read-only intact", CLR, A_RO, '0, 1'b0, 2'd0, 1'b0, RO_V);
    endtask

    task automatic t_bad;     // R8
        access("R8 unknown address", SET, A_BAD, '0, 1'b0, 2'd3, 1'b1, '0);
        access("R8 reserved op", NOP, A_U, 32'hFFFF, 1'b1, 2'd3, 1'b1, '0);
        access("R8 user reg intact", SET, A_U, '0, 1'b0, 2'd3, 1'b0, 32'h1);
    endtask

    task automatic t_timing;  // R9
        @(negedge clk); drive(RW, A_U, 32'h1, 1'b1, 2'd0);
        #0 check("R9 no response before edge", 1'b0, 1'b0, '0);
        @(posedge clk); #1 check("R9 response after edge", 1'b1, 1'b0, 32'h1);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1 check("R9 idle cycle", 1'b0, 1'b0, '0);
    endtask

    task automatic t_back2back; // R10
        @(negedge clk); drive(RW, A_U, 32'h10, 1'b1, 2'd0);
        @(posedge clk); #1 check("R10 first of pair", 1'b1, 1'b0, 32'h1);
        @(negedge clk); drive(SET, A_U, 32'h01, 1'b1, 2'd0);
        @(posedge clk); #1 check("R10 second sees first", 1'b1, 1'b0, 32'h10);
        @(negedge clk); req_valid = 1'b0;
        access("R10 combined result", SET, A_U, '0, 1'b0, 2'd0, 1'b0, 32'h11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset(); t_swap(); t_set(); t_clear(); t_zero_src();
        t_priv(); t_ro(); t_bad(); t_timing(); t_back2back();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule